// File: doc/BRIEF.md
# Segmented virtual address translator

This block turns a 32-bit virtual address into a 32-bit physical address. It first sorts the address into a fixed segment according to its top three bits and the current privilege mode. Depending on that segment, the access is refused, is passed through a direct window, or is looked up in a small fully associative translation buffer. In the buffer, each entry maps an even/odd pair of adjacent pages.

Each request carries a virtual address, an access kind (load, store or instruction fetch), a privilege mode and an address-space tag. One clock later the block returns a valid strobe, the physical address, a cache attribute and a signed result code. The code is zero on success. Each distinct fault has its own negative value. Software loads buffer entries through a write port that addresses an entry by index. An entry carries a masked page-pair number, a size mask, an address-space tag, a global flag and a hardware-kill flag, plus a frame number and permission bits for each half.

Top module: `seg_xlate`

## Requirements
- R1: The user mode is encoded as mode 2, and mode 3 is treated the same way. In user mode, any address at or above 0x80000000 returns code -1 (4'hF) and the buffer is not consulted.
- R2: In kernel mode (mode 0), addresses 0x80000000–0x9FFFFFFF and 0xA0000000–0xBFFFFFFF return code 0. The physical address is the virtual address with bits 31:29 cleared. The attribute is CACHED_ATTR (3) for the first window and UNCACHED_ATTR (2) for the second.
- R3: An entry matches when the virtual bits 31:13, with the bits under the entry mask ignored, equal the stored page-pair number, and either the global flag is set or the stored tag equals asid_i. On a clean hit the code is 0 and the attribute comes from the selected half.
- R4: The mask is a run of k low ones, giving pages of 4 KiB << k. Virtual bit 12+k selects the half: 0 selects even, 1 selects odd. The physical address takes bits below 12+k from the virtual address and the upper bits from the half's frame number shifted left by 12. Each half is packed as frame[26:7], attribute[6:4], valid[3], dirty[2], exec-inhibit[1], read-inhibit[0].
- R5: Faults are resolved in this priority order: no match (-2), then half not valid (-3), then read-inhibit on a load (-5) or exec-inhibit on a fetch (-6), then a store to a half whose dirty bit is clear (-4). The access kind is encoded as 0 load, 1 store, 2 fetch, and 3 is treated as a load. A store ignores both inhibit bits.
- R6: An entry whose kill flag is set never matches. After reset every entry has its kill flag set.
- R7: When several entries match, the lowest index wins.
- R8: A write replaces the indexed entry at the clock edge. A lookup presented in the same cycle as a write sees the previous contents of the buffer.
- R9: valid_o is high exactly one cycle after req_valid_i was high. Otherwise valid_o and all result outputs are zero, and they are also zero during reset.
- R10: In supervisor mode (mode 1), only addresses below 0x80000000 and addresses in 0xC0000000–0xDFFFFFFF are translated through the buffer. Every other address returns -1.
- R11: Whenever the code is nonzero, the physical address and the attribute are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| va_i | input | 32 | Virtual address |
| acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| mode_i | input | 2 | Privilege: 0 kernel, 1 supervisor, 2/3 user |
| asid_i | input | 8 | Current address-space tag |
| wr_en_i | input | 1 | Entry write enable |
| wr_idx_i | input | 4 | Entry index to write |
| wr_vpn2_i | input | 19 | Page-pair number (virtual bits 31:13) |
| wr_mask_i | input | 8 | Page size mask, contiguous low ones |
| wr_asid_i | input | 8 | Entry address-space tag |
| wr_global_i | input | 1 | Entry ignores the tag |
| wr_hinv_i | input | 1 | Entry kill flag, never matches |
| wr_even_i | input | 27 | Even half fields, packed as in R4 |
| wr_odd_i | input | 27 | Odd half fields, packed as in R4 |
| valid_o | output | 1 | Result strobe |
| pa_o | output | 32 | Physical address |
| code_o | output | 4 | Result code, two's complement |
| attr_o | output | 3 | Cache attribute |

## Verification
A write and a lookup to the same entry can happen in one cycle, and this is the collision that matters. The bench provokes it on purpose by driving both in one cycle: first an address that only the incoming entry would match, then the same address again in the next cycle. It judges the first result against the pre-write model, which must give no match, and the second against the post-write model, which must give a hit. The random phase mixes writes and lookups in the same cycles and uses the same rule. The model is updated only after the expected value for that cycle has been computed.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int MASK_W     = 8;
    localparam int ASID_W     = 8;
    localparam int PFN_W      = 20;
    localparam int ATTR_W     = 3;
    localparam int CODE_W     = 4;
    localparam int PA_W       = PFN_W + PAGE_SHIFT;
    localparam int VPN2_W     = VA_W - PAGE_SHIFT - 1;

    localparam logic [1:0] MODE_KERNEL = 2'd0;
    localparam logic [1:0] MODE_SUPER  = 2'd1;

    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam logic [CODE_W-1:0] RC_OK      = CODE_W'(0);
    localparam logic [CODE_W-1:0] RC_BADADDR = CODE_W'(-1);
    localparam logic [CODE_W-1:0] RC_NOHIT   = CODE_W'(-2);
    localparam logic [CODE_W-1:0] RC_INVALID = CODE_W'(-3);
    localparam logic [CODE_W-1:0] RC_DIRTY   = CODE_W'(-4);
    localparam logic [CODE_W-1:0] RC_RINH    = CODE_W'(-5);
    localparam logic [CODE_W-1:0] RC_XINH    = CODE_W'(-6);

    typedef enum logic [1:0] {
        SEG_BAD      = 2'd0,
        SEG_MAPPED   = 2'd1,
        SEG_DIRECT_C = 2'd2,
        SEG_DIRECT_U = 2'd3
    } seg_e;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              valid;
        logic              dirty;
        logic              xinh;
        logic              rinh;
    } half_t;

    localparam int HALF_W = $bits(half_t);

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [MASK_W-1:0] mask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic              hinv;
        half_t             even;
        half_t             odd;
    } entry_t;

    typedef struct packed {
        logic              vld;
        logic [PA_W-1:0]   pa;
        logic [CODE_W-1:0] code;
        logic [ATTR_W-1:0] attr;
    } result_t;

endpackage

// File: rtl/seg_decode.sv
module seg_decode
    import seg_xlate_pkg::*;
(
    input  logic [2:0] va_top_i,
    input  logic [1:0] mode_i,
    output seg_e       seg_o
);

    logic is_kernel;
    logic is_super;

    assign is_kernel = (mode_i == MODE_KERNEL);
    assign is_super  = (mode_i == MODE_SUPER);

    always_comb begin
        seg_o = SEG_BAD;
        if (!va_top_i[2]) begin
            seg_o = SEG_MAPPED;
        end else begin
            unique case (va_top_i[1:0])
                2'b00: seg_o = is_kernel ? SEG_DIRECT_C : SEG_BAD;
                2'b01: seg_o = is_kernel ? SEG_DIRECT_U : SEG_BAD;
                2'b10: seg_o = (is_kernel || is_super) ? SEG_MAPPED : SEG_BAD;
                default: seg_o = is_kernel ? SEG_MAPPED : SEG_BAD;
            endcase
        end
    end

endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
    import seg_xlate_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  entry_t            wr_entry_i,
    input  logic [VA_W-1:0]   lk_va_i,
    input  logic [ASID_W-1:0] lk_asid_i,
    output logic              hit_o,
    output half_t             half_o,
    output logic [PA_W-1:0]   pa_o
);

    localparam entry_t RST_ENTRY = '{hinv: 1'b1, default: '0};

    entry_t tbl_d [ENTRIES];
    entry_t tbl_q [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            tbl_d[i] = tbl_q[i];
        end
        if (wr_en_i && (int'(wr_idx_i) < ENTRIES)) begin
            tbl_d[wr_idx_i] = wr_entry_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl_q[i] <= RST_ENTRY;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

    logic [ENTRIES-1:0] hit_vec;
    logic [VPN2_W-1:0]  va_vpn2;

    assign va_vpn2 = lk_va_i[VA_W-1:PAGE_SHIFT+1];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VPN2_W-1:0] care;
        logic              tag_ok;
        assign care      = ~{{(VPN2_W-MASK_W){1'b0}}, tbl_q[g].mask};
        assign tag_ok    = tbl_q[g].glob || (tbl_q[g].asid == lk_asid_i);
        assign hit_vec[g] = !tbl_q[g].hinv && tag_ok
                            && (((va_vpn2 ^ tbl_q[g].vpn2) & care) == '0);
    end

    logic [IDX_W-1:0] sel_idx;

    always_comb begin
        sel_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_idx = IDX_W'(i);
            end
        end
    end

    entry_t            ent;
    logic [MASK_W:0]   odd_onehot;
    logic              odd_sel;
    logic [PA_W-1:0]   off_mask;

    assign ent        = tbl_q[sel_idx];
    assign odd_onehot = {ent.mask, 1'b1} & ~{1'b0, ent.mask};
    assign odd_sel    = |(lk_va_i[PAGE_SHIFT +: MASK_W+1] & odd_onehot);
    assign off_mask   = PA_W'({ent.mask, {PAGE_SHIFT{1'b1}}});

    assign hit_o  = |hit_vec;
    assign half_o = odd_sel ? ent.odd : ent.even;
    assign pa_o   = ({half_o.pfn, {PAGE_SHIFT{1'b0}}} & ~off_mask)
                  | (PA_W'(lk_va_i) & off_mask);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int              ENTRIES       = 16,
    parameter logic [2:0]      CACHED_ATTR   = 3'd3,
    parameter logic [2:0]      UNCACHED_ATTR = 3'd2,
    localparam int             IDX_W         = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [VA_W-1:0]   va_i,
    input  logic [1:0]        acc_i,
    input  logic [1:0]        mode_i,
    input  logic [ASID_W-1:0] asid_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [VPN2_W-1:0] wr_vpn2_i,
    input  logic [MASK_W-1:0] wr_mask_i,
    input  logic [ASID_W-1:0] wr_asid_i,
    input  logic              wr_global_i,
    input  logic              wr_hinv_i,
    input  logic [HALF_W-1:0] wr_even_i,
    input  logic [HALF_W-1:0] wr_odd_i,
    output logic              valid_o,
    output logic [PA_W-1:0]   pa_o,
    output logic [CODE_W-1:0] code_o,
    output logic [ATTR_W-1:0] attr_o
);

    localparam logic [PA_W-1:0] DIRECT_MASK = PA_W'({3'b000, {(VA_W-3){1'b1}}});

    seg_e            seg;
    logic            tlb_hit;
    half_t           tlb_half;
    logic [PA_W-1:0] tlb_pa;
    entry_t          wr_entry;

    assign wr_entry = '{vpn2: wr_vpn2_i, mask: wr_mask_i, asid: wr_asid_i,
                        glob: wr_global_i, hinv: wr_hinv_i,
                        even: half_t'(wr_even_i), odd: half_t'(wr_odd_i)};

    seg_decode u_seg (
        .va_top_i (va_i[VA_W-1:VA_W-3]),
        .mode_i   (mode_i),
        .seg_o    (seg)
    );

    pair_tlb #(.ENTRIES(ENTRIES)) u_tlb (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_idx_i   (wr_idx_i),
        .wr_entry_i (wr_entry),
        .lk_va_i    (va_i),
        .lk_asid_i  (asid_i),
        .hit_o      (tlb_hit),
        .half_o     (tlb_half),
        .pa_o       (tlb_pa)
    );

    result_t res_d, res_q;
    logic    is_store, is_fetch, is_load;

    assign is_store = (acc_i == ACC_STORE);
    assign is_fetch = (acc_i == ACC_FETCH);
    assign is_load  = !is_store && !is_fetch;

    always_comb begin
        res_d     = '0;
        res_d.vld = req_valid_i;
        if (req_valid_i) begin
            unique case (seg)
                SEG_BAD: res_d.code = RC_BADADDR;
                SEG_DIRECT_C: begin
                    res_d.pa   = PA_W'(va_i) & DIRECT_MASK;
                    res_d.attr = CACHED_ATTR;
                end
                SEG_DIRECT_U: begin
                    res_d.pa   = PA_W'(va_i) & DIRECT_MASK;
                    res_d.attr = UNCACHED_ATTR;
                end
                default: begin
                    if (!tlb_hit) begin
                        res_d.code = RC_NOHIT;
                    end else if (!tlb_half.valid) begin
                        res_d.code = RC_INVALID;
                    end else if (is_load && tlb_half.rinh) begin
                        res_d.code = RC_RINH;
                    end else if (is_fetch && tlb_half.xinh) begin
                        res_d.code = RC_XINH;
                    end else if (is_store && !tlb_half.dirty) begin
                        res_d.code = RC_DIRTY;
                    end else begin
                        res_d.pa   = tlb_pa;
                        res_d.attr = tlb_half.attr;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign valid_o = res_q.vld;
    assign pa_o    = res_q.pa;
    assign code_o  = res_q.code;
    assign attr_o  = res_q.attr;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic [VA_W-1:0]   va_i,
    input logic [1:0]        mode_i,
    input logic              valid_o,
    input logic [PA_W-1:0]   pa_o,
    input logic [CODE_W-1:0] code_o,
    input logic [ATTR_W-1:0] attr_o
);

    assert_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> valid_o);

    assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !valid_o);

    assert_user_bad_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && mode_i[1] && va_i[VA_W-1]) |=> (code_o == RC_BADADDR));

    assert_direct_pa_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && mode_i == MODE_KERNEL && va_i[VA_W-1:VA_W-2] == 2'b10)
        |=> (code_o == RC_OK && pa_o == (PA_W'($past(va_i)) & 32'h1FFF_FFFF)));

    assert_fault_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && code_o != RC_OK) |-> (pa_o == '0 && attr_o == '0));

    assert_code_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (code_o == RC_OK || code_o >= RC_XINH));

endmodule

bind seg_xlate seg_xlate_chk chk_i (.*);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] va = '0;
    logic [1:0]  acc = '0;
    logic [1:0]  mode = '0;
    logic [7:0]  asid = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [18:0] wr_vpn2 = '0;
    logic [7:0]  wr_mask = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_g = 1'b0;
    logic        wr_hinv = 1'b0;
    logic [26:0] wr_ev = '0;
    logic [26:0] wr_od = '0;
    logic        valid_o;
    logic [31:0] pa_o;
    logic [3:0]  code_o;
    logic [2:0]  attr_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    seg_xlate dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .va_i(va),
        .acc_i(acc), .mode_i(mode), .asid_i(asid), .wr_en_i(wr_en),
        .wr_idx_i(wr_idx), .wr_vpn2_i(wr_vpn2), .wr_mask_i(wr_mask),
        .wr_asid_i(wr_asid), .wr_global_i(wr_g), .wr_hinv_i(wr_hinv),
        .wr_even_i(wr_ev), .wr_odd_i(wr_od), .valid_o(valid_o),
        .pa_o(pa_o), .code_o(code_o), .attr_o(attr_o)
    );

    logic [18:0] m_vpn2 [16];
    logic [7:0]  m_mask [16];
    logic [7:0]  m_asid [16];
    logic        m_g    [16];
    logic        m_hinv [16];
    logic [26:0] m_ev   [16];
    logic [26:0] m_od   [16];

    function automatic logic [26:0] mk_half(logic [19:0] pfn, logic [2:0] at,
                                            logic v, logic d, logic xi, logic ri);
        return {pfn, at, v, d, xi, ri};
    endfunction

    // expected {pa, code, attr}
    function automatic logic [38:0] model(logic [31:0] a, logic [1:0] k,
                                          logic [1:0] md, logic [7:0] tag);
        logic [2:0]  top;
        int          hit_i;
        int          ones;
        logic [26:0] h;
        logic [31:0] off;
        logic [31:0] p;
        top = a[31:29];
        hit_i = -1;
        if (md >= 2 && a[31]) return {32'h0, 4'hF, 3'h0};
        if (md == 1 && a[31] && top != 3'b110) return {32'h0, 4'hF, 3'h0};
        if (md == 0 && top == 3'b100) return {a & 32'h1FFF_FFFF, 4'h0, 3'd3};
        if (md == 0 && top == 3'b101) return {a & 32'h1FFF_FFFF, 4'h0, 3'd2};
        for (int i = 15; i >= 0; i--) begin
            if (!m_hinv[i] && (((a[31:13] ^ m_vpn2[i]) & ~{11'h0, m_mask[i]}) == 19'h0)
                && (m_g[i] || m_asid[i] == tag)) hit_i = i;
        end
        if (hit_i < 0) return {32'h0, 4'hE, 3'h0};
        ones = 0;
        for (int b = 0; b < 8; b++) if (m_mask[hit_i][b]) ones++;
        h = a[12 + ones] ? m_od[hit_i] : m_ev[hit_i];
        if (!h[3]) return {32'h0, 4'hD, 3'h0};
        if ((k == 0 || k == 3) && h[0]) return {32'h0, 4'hB, 3'h0};
        if (k == 2 && h[1]) return {32'h0, 4'hA, 3'h0};
        if (k == 1 && !h[2]) return {32'h0, 4'hC, 3'h0};
        off = (32'h1000 << ones) - 32'h1;
        p = ({h[26:7], 12'h000} & ~off) | (a & off);
        return {p, 4'h0, h[6:4]};
    endfunction

    task automatic set_wr(int idx, logic [18:0] vp, logic [7:0] mk, logic [7:0] tg,
                          logic g, logic hv, logic [26:0] ev, logic [26:0] od);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn2 = vp; wr_mask = mk; wr_asid = tg;
        wr_g = g; wr_hinv = hv; wr_ev = ev; wr_od = od;
    endtask

    task automatic set_req(logic [31:0] a, logic [1:0] k, logic [1:0] md, logic [7:0] tg);
        req_valid = 1'b1; va = a; acc = k; mode = md; asid = tg;
    endtask

    // one cycle: expectation from pre-edge model, then model write, then compare
    task automatic step(string tag);
        logic [38:0] exp;
        logic        exp_v;
        exp_v = req_valid;
        exp = req_valid ? model(va, acc, mode, asid) : 39'h0;
        @(posedge clk);
        if (wr_en) begin
            m_vpn2[wr_idx] = wr_vpn2; m_mask[wr_idx] = wr_mask; m_asid[wr_idx] = wr_asid;
            m_g[wr_idx] = wr_g; m_hinv[wr_idx] = wr_hinv;
            m_ev[wr_idx] = wr_ev; m_od[wr_idx] = wr_od;
        end
        @(negedge clk);
        total++;
        if (valid_o !== exp_v || {pa_o, code_o, attr_o} !== exp) begin
            bad++;
            $display("FAIL %s: got v=%0b pa=%h code=%h attr=%0d exp v=%0b pa=%h code=%h attr=%0d",
                     tag, valid_o, pa_o, code_o, attr_o, exp_v, exp[38:7], exp[6:3], exp[2:0]);
        end
        req_valid = 1'b0;
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout exp finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        for (int i = 0; i < 16; i++) begin
            m_vpn2[i] = '0; m_mask[i] = '0; m_asid[i] = '0; m_g[i] = 1'b0;
            m_hinv[i] = 1'b1; m_ev[i] = '0; m_od[i] = '0;
        end
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        total++;
        if (valid_o !== 1'b0 || pa_o !== '0 || code_o !== '0) begin
            bad++;
            $display("FAIL R9 reset: got v=%0b code=%h exp v=0 code=0", valid_o, code_o);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reset entries never match
        set_req(32'h0040_0000, 0, 0, 8'd5); step("R6 reset no match");
        // R9: no request gives no strobe
        step("R9 idle");
        // R1 user bad
        set_req(32'h8000_0000, 0, 2, 8'd5); step("R1 user kseg");
        set_req(32'hFFFF_FFFF, 2, 3, 8'd5); step("R1 user mode3 top");
        // R10 supervisor
        set_req(32'hC000_1000, 0, 1, 8'd5); step("R10 super mapped window");
        set_req(32'hA000_0000, 0, 1, 8'd5); step("R10 super direct refused");
        set_req(32'hE000_0000, 0, 1, 8'd5); step("R10 super top refused");
        // R2 direct windows
        set_req(32'h8123_4567, 1, 0, 8'd0); step("R2 cached window");
        set_req(32'hBFFF_FFFC, 2, 0, 8'd0); step("R2 uncached window");

        // R3 / R4 basic entry, 4 KiB pages
        set_wr(0, 19'h00200, 8'h00, 8'd5, 1'b0, 1'b0,
               mk_half(20'h12345, 3'd3, 1, 1, 0, 0), mk_half(20'h54321, 3'd1, 1, 0, 0, 0));
        step("R8 write entry0");
        set_req(32'h0040_0123, 0, 0, 8'd5); step("R3 tag hit even");
        set_req(32'h0040_0123, 0, 0, 8'd6); step("R3 tag mismatch");
        set_req(32'h0040_1FFF, 0, 0, 8'd5); step("R4 odd half");
        set_req(32'h0040_1FFF, 1, 0, 8'd5); step("R5 store clean dirty fault");

        // R4 16 KiB pages, global
        set_wr(1, 19'h08000, 8'h03, 8'd9, 1'b1, 1'b0,
               mk_half(20'h00100, 3'd4, 1, 1, 0, 0), mk_half(20'h00200, 3'd5, 1, 1, 0, 0));
        step("R8 write entry1");
        set_req(32'h1000_3ABC, 0, 0, 8'd1); step("R4 large page even global");
        set_req(32'h1000_4010, 2, 0, 8'd2); step("R4 large page odd");

        // R5 fault ordering
        set_wr(2, 19'h10000, 8'h00, 8'd5, 1'b0, 1'b0,
               mk_half(20'h0AAAA, 3'd3, 0, 1, 1, 1), mk_half(20'h0BBBB, 3'd3, 1, 0, 1, 1));
        step("R8 write entry2");
        set_req(32'h2000_0000, 2, 0, 8'd5); step("R5 invalid before inhibit");
        set_req(32'h2000_1000, 0, 0, 8'd5); step("R5 read inhibit");
        set_req(32'h2000_1000, 3, 0, 8'd5); step("R5 kind3 as load");
        set_req(32'h2000_1000, 2, 0, 8'd5); step("R5 exec inhibit");
        set_req(32'h2000_1000, 1, 0, 8'd5); step("R5 store ignores inhibit");

        // R6 killed entry
        set_wr(3, 19'h18000, 8'h00, 8'd0, 1'b1, 1'b1,
               mk_half(20'h0CCCC, 3'd3, 1, 1, 0, 0), mk_half(20'h0CCCC, 3'd3, 1, 1, 0, 0));
        step("R8 write entry3");
        set_req(32'h3000_0000, 0, 0, 8'd0); step("R6 killed never matches");

        // R7 priority
        set_wr(5, 19'h20000, 8'h00, 8'd0, 1'b1, 1'b0,
               mk_half(20'h0BBBB, 3'd1, 1, 1, 0, 0), mk_half(20'h0BBBB, 3'd1, 1, 1, 0, 0));
        step("R8 write entry5");
        set_wr(4, 19'h20000, 8'h00, 8'd0, 1'b1, 1'b0,
               mk_half(20'h0AAAA, 3'd2, 1, 1, 0, 0), mk_half(20'h0AAAA, 3'd2, 1, 1, 0, 0));
        step("R8 write entry4");
        set_req(32'h4000_0040, 0, 0, 8'd0); step("R7 lowest index");
        set_wr(4, 19'h20000, 8'h00, 8'd0, 1'b1, 1'b1, 27'h0, 27'h0);
        step("R8 kill entry4");
        set_req(32'h4000_0040, 0, 0, 8'd0); step("R7 next index");

        // R8 write and lookup in the same cycle
        set_wr(6, 19'h28000, 8'h00, 8'd7, 1'b0, 1'b0,
               mk_half(20'h0DDDD, 3'd6, 1, 1, 0, 0), mk_half(20'h0EEEE, 3'd6, 1, 1, 0, 0));
        set_req(32'h5000_0010, 0, 0, 8'd7); step("R8 same cycle sees old");
        set_req(32'h5000_0010, 0, 0, 8'd7); step("R8 next cycle sees new");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int e;
            logic [7:0] mk;
            e = int'($urandom_range(15, 0));
            if ($urandom_range(3, 0) == 0) begin
                case ($urandom_range(3, 0))
                    0: mk = 8'h00;
                    1: mk = 8'h01;
                    2: mk = 8'h03;
                    default: mk = 8'h0F;
                endcase
                set_wr(e, 19'($urandom), mk, 8'($urandom_range(3, 1)),
                       1'($urandom_range(3, 0) == 0), 1'($urandom_range(7, 0) == 0),
                       27'($urandom), 27'($urandom));
            end
            if ($urandom_range(7, 0) != 0) begin
                e = int'($urandom_range(15, 0));
                set_req({m_vpn2[e], 13'($urandom)} ^ (($urandom_range(5, 0) == 0) ? 32'($urandom) : 32'h0),
                        2'($urandom), ($urandom_range(3, 0) == 0) ? 2'($urandom) : 2'd0,
                        8'($urandom_range(3, 1)));
            end
            step("R3 R4 R5 R8 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule